// File: doc/BRIEF.md
# Supply-Loss Access Guard

This block stands between a memory's external bus controls and its storage core and decides, cycle by cycle, whether an access may reach the core. It watches three comparator flags: supply above the upper trip, supply below the lower trip, and supply below the battery switchover level. The moment the supply leaves the valid band the gated select, write strobe and output drive are all forced low, and the bus inputs stop having any effect. Below the switchover level the block requests the battery source.

When the supply comes back, protection is not released at once. The supply must stay valid for a programmable recovery time, counted in system clock cycles. After that the bus must be seen idle for at least one cycle before any access is granted. A cycle that was left half done before the loss therefore cannot resume by itself.

Top module: `pfail_gate`

## Requirements
- R1: While reset is high, and right after it, mem_sel, mem_wr, dq_drive and bat_sel are all 0. Reset leaves the block in the recovery phase with a zero count, so access is granted only after a full recovery time.
- R2: In normal operation the bus is active when bus_ce_n=0 and bus_ce2=1. Then mem_sel=1, mem_wr = !bus_we_n, and dq_drive = bus_we_n && !bus_oe_n. When the bus is not active, all three are 0. The outputs follow the bus inputs in the same cycle.
- R3: Each comparator flag passes through exactly two synchronizing flops. A change driven between clock edges has no effect after one edge and takes effect after the second.
- R4: Once the synchronized flags show the supply below the upper trip (sup_ok_in=0), below the lower trip (sup_low_in=1) or below switchover (sup_bat_in=1), mem_sel, mem_wr and dq_drive are 0 in that same cycle. This does not wait for a bus cycle to end. Every bus input pattern is then ignored.
- R5: A write held active across a supply loss is cut off at the R4 point. It does not come back when power returns, even if bus_we_n is still held low.
- R6: bat_sel rises one clock edge after the synchronized below-switchover flag is seen high, which is three edges after the raw flag rises. It falls three edges after the raw flag falls.
- R7: With the supply valid again, protection stays on for REC_CYC cycles. With an idle bus, the first access is granted REC_CYC+4 edges after the raw flags return to good, and not one edge earlier.
- R8: Any dip below the upper trip during recovery restarts the full count. With a one-cycle dip, access is granted REC_CYC+5 edges after the dip begins.
- R9: After protection ends, no access is granted until the bus has been seen inactive at one clock edge. An access held active through the release stays blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_ok_in | input | 1 | Comparator: supply above upper trip (asynchronous) |
| sup_low_in | input | 1 | Comparator: supply below lower trip (asynchronous) |
| sup_bat_in | input | 1 | Comparator: supply below switchover (asynchronous) |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_ce2 | input | 1 | Bus chip enable, active high |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| mem_sel | output | 1 | Gated core select |
| mem_wr | output | 1 | Gated core write strobe |
| dq_drive | output | 1 | Data output drive enable (0 means high-Z) |
| bat_sel | output | 1 | Battery source select |

## Verification
The hardest situation to reach is the exact release edge. Release depends on the synchronizer delay, the recovery count and the idle re-arm cycle all lining up. A dip in the middle of recovery is harder still. The stimulus therefore power-cycles the block once per trial and sweeps the wait after power-good, and after a one-cycle dip, across every edge count around the expected release. At each count it raises an access and compares the grant against the arithmetic boundary.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_PROTECT = 2'd1,
        ST_BATTERY = 2'd2,
        ST_RECOVER = 2'd3
    } pwr_state_t;

    // comparator flags, ok is the MSB
    typedef struct packed {
        logic ok;
        logic low;
        logic bat;
    } sup_flags_t;

    typedef struct packed {
        logic ce_n;
        logic ce2;
        logic oe_n;
        logic we_n;
    } bus_ctl_t;

    typedef struct packed {
        logic sel;
        logic wr;
        logic drive;
    } mem_ctl_t;

    localparam int SYNC_STAGES = 2;

    // synchronizer reset value: supply assumed bad
    localparam sup_flags_t FLAGS_RESET = 3'b010;

    function automatic logic bus_active(input bus_ctl_t b);
        return !b.ce_n && b.ce2;
    endfunction

    function automatic logic supply_unsafe(input sup_flags_t f);
        return !f.ok || f.low || f.bat;
    endfunction

endpackage

// File: rtl/pfail_sync.sv
module pfail_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pfail_fsm.sv
module pfail_fsm
    import pfail_pkg::*;
#(
    parameter int REC_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  sup_flags_t flg,
    output pwr_state_t state,
    output logic       bat_sel
);
    localparam int CW = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(REC_CYC - 1);

    pwr_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = '0;
        if (flg.bat) begin
            st_d = ST_BATTERY;
        end else if (!flg.ok || flg.low) begin
            st_d = ST_PROTECT;
        end else begin
            unique case (st_q)
                ST_NORMAL:  st_d = ST_NORMAL;
                ST_PROTECT,
                ST_BATTERY: st_d = ST_RECOVER;
                ST_RECOVER: begin
                    if (cnt_q == CNT_LAST) st_d = ST_NORMAL;
                    else                   cnt_d = cnt_q + 1'b1;
                end
                default:    st_d = ST_PROTECT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RECOVER;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state   = st_q;
    assign bat_sel = (st_q == ST_BATTERY);
endmodule

// File: rtl/pfail_access.sv
module pfail_access
    import pfail_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     prot,
    input  bus_ctl_t bus,
    output mem_ctl_t mc
);
    logic armed_q;
    logic act;
    logic grant;

    assign act = bus_active(bus);

    // re-arm only after the bus is seen idle while unprotected
    always_ff @(posedge clk) begin
        if (rst)       armed_q <= 1'b0;
        else if (prot) armed_q <= 1'b0;
        else           armed_q <= armed_q | !act;
    end

    assign grant    = !prot && armed_q && act;
    assign mc.sel   = grant;
    assign mc.wr    = grant && !bus.we_n;
    assign mc.drive = grant && bus.we_n && !bus.oe_n;
endmodule

// File: rtl/pfail_gate.sv
module pfail_gate
    import pfail_pkg::*;
#(
    parameter int REC_CYC = 4_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_ok_in,
    input  logic sup_low_in,
    input  logic sup_bat_in,
    input  logic bus_ce_n,
    input  logic bus_ce2,
    input  logic bus_oe_n,
    input  logic bus_we_n,
    output logic mem_sel,
    output logic mem_wr,
    output logic dq_drive,
    output logic bat_sel
);
    sup_flags_t raw_flags;
    sup_flags_t s_flags;
    pwr_state_t fsm_state;
    bus_ctl_t   bus;
    mem_ctl_t   mc;
    logic       prot;

    assign raw_flags = '{ok: sup_ok_in, low: sup_low_in, bat: sup_bat_in};
    assign bus       = '{ce_n: bus_ce_n, ce2: bus_ce2, oe_n: bus_oe_n, we_n: bus_we_n};

    pfail_sync #(
        .WIDTH  ($bits(sup_flags_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(FLAGS_RESET)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_flags),
        .q  (s_flags)
    );

    pfail_fsm #(.REC_CYC(REC_CYC)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .flg    (s_flags),
        .state  (fsm_state),
        .bat_sel(bat_sel)
    );

    // protection is immediate on the synchronized flags
    assign prot = (fsm_state != ST_NORMAL) || supply_unsafe(s_flags);

    pfail_access u_acc (
        .clk (clk),
        .rst (rst),
        .prot(prot),
        .bus (bus),
        .mc  (mc)
    );

    assign mem_sel  = mc.sel;
    assign mem_wr   = mc.wr;
    assign dq_drive = mc.drive;
endmodule

// File: rtl/pfail_gate_chk.sv
module pfail_gate_chk
    import pfail_pkg::*;
#(
    parameter int REC_CYC = 4
) (
    input logic       clk,
    input logic       rst,
    input sup_flags_t s_flags,
    input pwr_state_t state,
    input logic       mem_sel,
    input logic       mem_wr,
    input logic       dq_drive,
    input logic       bat_sel
);
    localparam int CW = $clog2(REC_CYC + 2);
    logic [CW-1:0] rec_run;

    always_ff @(posedge clk) begin
        if (rst)                      rec_run <= '0;
        else if (state == ST_RECOVER) rec_run <= rec_run + 1'b1;
        else                          rec_run <= '0;
    end

    p_blocked_unsafe_r4: assert property (@(posedge clk) disable iff (rst)
        supply_unsafe(s_flags) |-> (!mem_sel && !mem_wr && !dq_drive));

    p_wr_needs_sel_r2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_sel && !dq_drive));

    p_bat_enter_r6: assert property (@(posedge clk) disable iff (rst)
        s_flags.bat |=> bat_sel);

    p_bat_leave_r6: assert property (@(posedge clk) disable iff (rst)
        (bat_sel && !s_flags.bat) |=> !bat_sel);

    p_release_count_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && rec_run != '0) |-> (rec_run == CW'(REC_CYC)));

    p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(state) != ST_NORMAL) |-> !mem_sel);
endmodule

bind pfail_gate pfail_gate_chk #(.REC_CYC(REC_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_flags (s_flags),
    .state   (fsm_state),
    .mem_sel (mem_sel),
    .mem_wr  (mem_wr),
    .dq_drive(dq_drive),
    .bat_sel (bat_sel)
);

// File: tb/pfail_gate_bench.sv
`timescale 1ns/1ps
module pfail_gate_bench;
    localparam int REC = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ok = 1'b1, low = 1'b0, bat = 1'b0;
    logic ce_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic mem_sel, mem_wr, dq_drive, bat_sel;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pfail_gate #(.REC_CYC(REC)) u_pfail_gate (
        .clk(clk), .rst(rst),
        .sup_ok_in(ok), .sup_low_in(low), .sup_bat_in(bat),
        .bus_ce_n(ce_n), .bus_ce2(ce2), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .mem_sel(mem_sel), .mem_wr(mem_wr), .dq_drive(dq_drive), .bat_sel(bat_sel)
    );

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {mem_sel, mem_wr, dq_drive, bat_sel};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got sel/wr/drv/bat=%b expected %b", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_read();
        ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    endtask

    task automatic power_off();
        ok = 1'b0; low = 1'b1; bat = 1'b1;
        bus_idle();
        edges(5);
    endtask

    task automatic power_good();
        ok = 1'b1; low = 1'b0; bat = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: reset state with an active bus
        bus_read();
        edges(3);
        #1 check("R1 during reset", 4'b0000);
        rst = 1'b0;
        bus_idle();
        edges(1);
        #1 check("R1 after reset", 4'b0000);
        edges(REC + 2);   // now REC+3 edges after release
        // R9: active access right at release is not granted, held active stays blocked
        bus_read();
        #1 check("R9 not armed at release", 4'b0000);
        edges(1);
        #1 check("R9 held active stays blocked", 4'b0000);
        bus_idle();
        edges(1);
        bus_read();
        #1 check("R9 granted after idle", 4'b1010);

        // R2: exhaustive bus sweep in normal operation
        for (int v = 0; v < 16; v++) begin
            logic e_sel;
            {ce_n, ce2, oe_n, we_n} = 4'(v);
            e_sel = !ce_n && ce2;
            #1 check("R2 bus sweep",
                     {e_sel, e_sel && !we_n, e_sel && we_n && !oe_n, 1'b0});
            edges(1);
        end

        // R3/R4/R5: write held across a supply loss
        ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b0;
        #1 check("R2 write before loss", 4'b1100);
        edges(1);
        ok = 1'b0;
        edges(1);
        #1 check("R3 one edge no effect", 4'b1100);
        edges(1);
        #1 check("R4 R5 write cut after two edges", 4'b0000);
        for (int v = 0; v < 16; v++) begin
            {ce_n, ce2, oe_n, we_n} = 4'(v);
            #1 check("R4 bus ignored while unsafe", 4'b0000);
            edges(1);
        end
        ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b0;

        // R6: battery select timing
        bat = 1'b1;
        edges(2);
        #1 check("R6 bat not yet after two edges", 4'b0000);
        edges(1);
        #1 check("R6 bat after three edges", 4'b0001);
        bat = 1'b0;
        edges(2);
        #1 check("R6 bat held two edges after drop", 4'b0001);
        edges(1);
        #1 check("R6 bat released three edges after drop", 4'b0000);

        // R5: power returns, write still held, never resumes by itself
        power_good();
        edges(REC + 10);
        #1 check("R5 held write does not resume", 4'b0000);
        bus_idle();
        edges(1);
        ce_n = 1'b0; we_n = 1'b0;
        #1 check("R5 new write after idle", 4'b1100);

        // R7: sweep the wait after power-good around the release edge
        for (int k = REC + 1; k <= REC + 6; k++) begin
            power_off();
            power_good();
            edges(k);
            bus_read();
            #1 check("R7 release boundary",
                     (k >= REC + 4) ? 4'b1010 : 4'b0000);
            bus_idle();
        end

        // R8: a one-cycle dip during recovery restarts the count
        for (int j = REC + 3; j <= REC + 6; j++) begin
            power_off();
            power_good();
            edges(REC / 2);
            ok = 1'b0;
            edges(1);
            ok = 1'b1;
            edges(j - 1);
            bus_read();
            #1 check("R8 restart after dip",
                     (j >= REC + 5) ? 4'b1010 : 4'b0000);
            bus_idle();
        end

        // R4: low-trip flag alone also blocks
        edges(2);
        bus_read();
        #1 check("R2 read before low trip", 4'b1010);
        low = 1'b1;
        edges(2);
        #1 check("R4 low trip blocks", 4'b0000);

        finish_run();
    end
endmodule